// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block sits between the digital back end of a two-channel (I and Q) 14-bit converter and its parallel output pins. Every sample clock it takes one raw offset-binary result per channel, together with that channel's overrange and underrange indications. It clamps any out-of-range sample to the matching full-scale code. It then registers both words in either offset binary or two's complement form, together with a single overflow flag that covers both channels.

A two-bit mode code picks the output format and also sets an enable output for the clock duty-cycle stabilizer. The code is held in a small state machine with four states: `ST_BIN_FREE` (code 00, offset binary, stabilizer off), `ST_BIN_STAB` (01, offset binary, stabilizer on), `ST_TWOS_STAB` (10, two's complement, stabilizer on) and `ST_TWOS_FREE` (11, two's complement, stabilizer off). On every clock edge outside reset, the machine moves to the state named by the code at its input, so every one of the sixteen transitions exists. Reset always enters `ST_BIN_FREE`.

The overflow flag is suppressed while the I channel is asleep or napping. An output-enable input forces every data and flag pin to zero without stalling the formatting pipeline.

Top module: `adc_fmt_top`

## Requirements
- R1: While `rst_n` is low, `i_data`, `q_data`, `ovf` and `stab_en` are all 0, and the mode state is `ST_BIN_FREE`.
- R2: In offset-binary format, an in-range sample presented at clock edge k appears unchanged on its data output after edge k, which is one cycle of latency.
- R3: In two's-complement format, an in-range output word equals the raw offset-binary word with bit 13 inverted.
- R4: An overrange sample outputs 14'h3FFF in offset binary and 14'h1FFF in two's complement.
- R5: An underrange sample outputs 14'h0000 in offset binary and 14'h2000 in two's complement.
- R6: When overrange and underrange are both high for one channel on the same sample, the overrange code of R4 is output.
- R7: `ovf` is 1 after edge k when either channel had overrange or underrange high at edge k, and 0 when both channels were in range. It is aligned with the data of that same sample.
- R8: `ovf` is 0 for every sample taken while `i_pwrdn` (1 = I channel asleep or napping) is high, whatever the range flags.
- R9: `stab_en` is 1 after an edge that sampled mode code 01 or 10, and 0 after an edge that sampled 00 or 11.
- R10: Codes 00 and 01 select offset binary; codes 10 and 11 select two's complement. A mode code sampled at edge k sets the format of the words registered at edge k+1 and later, so a word is never formatted with a mode that changed during its own cycle.
- R11: With `oe` low, `i_data`, `q_data` and `ovf` are 0. The pipeline keeps registering, so raising `oe` between edges at once shows the last registered sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_in | input | 2 | Format / stabilizer code (00, 01, 10, 11) |
| oe | input | 1 | Output enable; low forces outputs to zero |
| i_pwrdn | input | 1 | I channel asleep or napping |
| i_raw | input | 14 | I channel raw result, offset binary |
| i_over | input | 1 | I channel overrange |
| i_under | input | 1 | I channel underrange |
| q_raw | input | 14 | Q channel raw result, offset binary |
| q_over | input | 1 | Q channel overrange |
| q_under | input | 1 | Q channel underrange |
| i_data | output | 14 | I channel formatted word |
| q_data | output | 14 | Q channel formatted word |
| ovf | output | 1 | Shared overflow flag |
| stab_en | output | 1 | Duty-cycle stabilizer enable |

## Verification
The hardest cases to reach are the mode boundary, where a word must use the code sampled one edge before it and not the one that arrives alongside it, and a range event that falls while the I channel is powered down. The stimulus changes the mode code on the same edge as clamp-inducing samples. It walks all four codes back to back, and it asserts both range flags on both channels while `i_pwrdn` is high. A behavioural model in the bench keeps the previous code separately and is compared with the outputs every cycle. A mid-cycle toggle of `oe` shows that the pipeline kept running while the outputs were held at zero.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    // Registered format / stabilizer state; the encoding equals the mode code.
    typedef enum logic [1:0] {
        ST_BIN_FREE  = 2'b00,
        ST_BIN_STAB  = 2'b01,
        ST_TWOS_STAB = 2'b10,
        ST_TWOS_FREE = 2'b11
    } fmt_state_e;

endpackage

// File: rtl/adc_mode_fsm.sv
module adc_mode_fsm
    import adc_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_in,
    output logic       twos_o,
    output logic       stab_o
);

    fmt_state_e state_q;
    fmt_state_e state_d;

    // next state: every code maps directly onto its state
    always_comb begin
        unique case (mode_in)
            2'b00: state_d = ST_BIN_FREE;
            2'b01: state_d = ST_BIN_STAB;
            2'b10: state_d = ST_TWOS_STAB;
            2'b11: state_d = ST_TWOS_FREE;
            default: state_d = ST_BIN_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BIN_FREE;
        else        state_q <= state_d;
    end

    // outputs per state
    always_comb begin
        unique case (state_q)
            ST_BIN_FREE:  begin twos_o = 1'b0; stab_o = 1'b0; end
            ST_BIN_STAB:  begin twos_o = 1'b0; stab_o = 1'b1; end
            ST_TWOS_STAB: begin twos_o = 1'b1; stab_o = 1'b1; end
            ST_TWOS_FREE: begin twos_o = 1'b1; stab_o = 1'b0; end
            default:      begin twos_o = 1'b0; stab_o = 1'b0; end
        endcase
    end

    // R9
    stab_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == 2'b01 || mode_in == 2'b10) |=> stab_o);
    // R9
    stab_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == 2'b00 || mode_in == 2'b11) |=> !stab_o);
    // R10
    fmt_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (twos_o == $past(mode_in[1])));

endmodule

// File: rtl/adc_chan_fmt.sv
module adc_chan_fmt #(
    parameter int W = 14
) (
    input  logic [W-1:0] raw_i,
    input  logic         over_i,
    input  logic         under_i,
    input  logic         twos_i,
    output logic [W-1:0] word_o
);

    localparam logic [W-1:0] FS_HI = '1;
    localparam logic [W-1:0] FS_LO = '0;

    logic [W-1:0] bin_w;

    // clamp in offset binary; overrange wins over underrange
    always_comb begin
        if (over_i)       bin_w = FS_HI;
        else if (under_i) bin_w = FS_LO;
        else              bin_w = raw_i;
    end

    // two's complement differs from offset binary only in the MSB
    always_comb begin
        word_o        = bin_w;
        word_o[W-1]   = bin_w[W-1] ^ twos_i;
    end

endmodule

// File: rtl/adc_ovf_merge.sv
module adc_ovf_merge #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] over_i,
    input  logic [NCH-1:0] under_i,
    input  logic           pwrdn_i,
    output logic           ovf_o
);

    always_comb begin
        ovf_o = ((|over_i) | (|under_i)) & ~pwrdn_i;
    end

endmodule

// File: rtl/adc_fmt_top.sv
module adc_fmt_top #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_in,
    input  logic         oe,
    input  logic         i_pwrdn,
    input  logic [W-1:0] i_raw,
    input  logic         i_over,
    input  logic         i_under,
    input  logic [W-1:0] q_raw,
    input  logic         q_over,
    input  logic         q_under,
    output logic [W-1:0] i_data,
    output logic [W-1:0] q_data,
    output logic         ovf,
    output logic         stab_en
);

    localparam int NCH = 2;
    localparam logic [W-1:0] BIN_HI  = '1;
    localparam logic [W-1:0] TWOS_HI = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] BIN_LO  = '0;
    localparam logic [W-1:0] TWOS_LO = {1'b1, {(W-1){1'b0}}};

    logic           twos;
    logic [W-1:0]   raw_a  [NCH];
    logic [NCH-1:0] over_a;
    logic [NCH-1:0] under_a;
    logic [W-1:0]   word_a [NCH];
    logic [W-1:0]   word_q [NCH];
    logic           ovf_d;
    logic           ovf_q;
    logic           armed_q;

    assign raw_a[0] = i_raw;
    assign raw_a[1] = q_raw;
    assign over_a   = {q_over, i_over};
    assign under_a  = {q_under, i_under};

    adc_mode_fsm u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (mode_in),
        .twos_o  (twos),
        .stab_o  (stab_en)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        adc_chan_fmt #(.W(W)) u_fmt (
            .raw_i   (raw_a[c]),
            .over_i  (over_a[c]),
            .under_i (under_a[c]),
            .twos_i  (twos),
            .word_o  (word_a[c])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) word_q[c] <= '0;
            else        word_q[c] <= word_a[c];
        end
    end

    adc_ovf_merge #(.NCH(NCH)) u_ovf (
        .over_i  (over_a),
        .under_i (under_a),
        .pwrdn_i (i_pwrdn),
        .ovf_o   (ovf_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            ovf_q   <= ovf_d;
            armed_q <= 1'b1;
        end
    end

    // output enable gates the pins only; registers keep running
    always_comb begin
        i_data = oe ? word_q[0] : '0;
        q_data = oe ? word_q[1] : '0;
        ovf    = oe ? ovf_q     : 1'b0;
    end

    // R4 and R6
    i_over_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(i_over) |-> (word_q[0] == ($past(twos) ? TWOS_HI : BIN_HI)));
    // R5
    q_under_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(q_under) && !$past(q_over)) |-> (word_q[1] == ($past(twos) ? TWOS_LO : BIN_LO)));
    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (($past(i_over) || $past(i_under) || $past(q_over) || $past(q_under)) && !$past(i_pwrdn))
        |-> ovf_q);
    // R8
    ovf_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(i_pwrdn) |-> !ovf_q);
    // R11
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (i_data == '0 && q_data == '0 && !ovf));

endmodule

// File: tb/tb_adc_fmt_top.sv
`timescale 1ns/1ps
module tb_adc_fmt_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_in = 2'b00;
    logic        oe = 1'b1;
    logic        i_pwrdn = 1'b0;
    logic [13:0] i_raw = '0;
    logic        i_over = 1'b0;
    logic        i_under = 1'b0;
    logic [13:0] q_raw = '0;
    logic        q_over = 1'b0;
    logic        q_under = 1'b0;
    logic [13:0] i_data;
    logic [13:0] q_data;
    logic        ovf;
    logic        stab_en;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    adc_fmt_top dut (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .oe(oe), .i_pwrdn(i_pwrdn),
        .i_raw(i_raw), .i_over(i_over), .i_under(i_under),
        .q_raw(q_raw), .q_over(q_over), .q_under(q_under),
        .i_data(i_data), .q_data(q_data), .ovf(ovf), .stab_en(stab_en)
    );

    // behavioural reference
    int m_mode = 0;
    int m_i = 0;
    int m_q = 0;
    int m_ovf = 0;

    function automatic int fmt(int raw, bit over, bit under, int mode);
        int v;
        if (over)       v = 16383;
        else if (under) v = 0;
        else            v = raw;
        if (mode >= 2) v = (v >= 8192) ? v - 8192 : v + 8192;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_i = 0; m_q = 0; m_ovf = 0;
        end else begin
            m_i   = fmt(int'(i_raw), i_over, i_under, m_mode);
            m_q   = fmt(int'(q_raw), q_over, q_under, m_mode);
            m_ovf = (!i_pwrdn && (i_over || i_under || q_over || q_under)) ? 1 : 0;
            m_mode = int'(mode_in);
        end
    end

    task automatic check(input bit ok, input string t, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int ei, eq, eo, es;
        ei = oe ? m_i : 0;
        eq = oe ? m_q : 0;
        eo = oe ? m_ovf : 0;
        es = (m_mode == 1 || m_mode == 2) ? 1 : 0;
        check(int'(i_data) == ei, tag, "i_data", int'(i_data), ei);
        check(int'(q_data) == eq, tag, "q_data", int'(q_data), eq);
        check(int'(ovf) == eo, tag, "ovf", int'(ovf), eo);
        check(int'(stab_en) == es, tag, "stab_en", int'(stab_en), es);
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
    endtask

    task automatic put(input int ir, input bit io, input bit iu, input int qr, input bit qo, input bit qu);
        i_raw = 14'(ir); i_over = io; i_under = iu;
        q_raw = 14'(qr); q_over = qo; q_under = qu;
    endtask

    function automatic void summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endfunction

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: reset with busy inputs
        tag = "R1";
        mode_in = 2'b10;
        put(16'h1234, 1, 0, 16'h0FFF, 0, 1);
        repeat (3) begin
            @(negedge clk);
            check(i_data == 0 && q_data == 0 && ovf == 0 && stab_en == 0, "R1", "reset outputs",
                  int'({i_data, q_data, ovf, stab_en}), 0);
        end
        mode_in = 2'b00;
        put(0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        cyc();

        // R2: offset binary, in range
        tag = "R2";
        for (int n = 0; n < 20; n++) begin
            put(int'($urandom_range(0, 16383)), 0, 0, int'($urandom_range(0, 16383)), 0, 0);
            cyc();
        end
        put(0, 0, 0, 16383, 0, 0); cyc();
        put(8192, 0, 0, 8191, 0, 0); cyc();

        // R3: two's complement, in range (first word still binary per R10)
        tag = "R3";
        mode_in = 2'b10;
        for (int n = 0; n < 20; n++) begin
            put(int'($urandom_range(0, 16383)), 0, 0, int'($urandom_range(0, 16383)), 0, 0);
            cyc();
        end

        // R4, R5, R6, R7 in both formats
        for (int f = 0; f < 2; f++) begin
            mode_in = f ? 2'b11 : 2'b00;
            tag = "R10"; put(100, 0, 0, 200, 0, 0); cyc();
            tag = "R4";  put(5, 1, 0, 6, 0, 0); cyc();
            tag = "R4";  put(5, 0, 0, 6, 1, 0); cyc();
            tag = "R5";  put(777, 0, 1, 888, 0, 0); cyc();
            tag = "R5";  put(777, 0, 0, 888, 0, 1); cyc();
            tag = "R6";  put(42, 1, 1, 43, 1, 1); cyc();
            tag = "R7";  put(4000, 0, 0, 9000, 0, 0); cyc();
        end

        // R8: I channel powered down hides every range event
        tag = "R8";
        i_pwrdn = 1'b1;
        put(1, 1, 0, 2, 0, 0); cyc();
        put(1, 0, 0, 2, 1, 1); cyc();
        put(1, 1, 1, 2, 1, 1); cyc();
        i_pwrdn = 1'b0;
        tag = "R7";
        put(1, 0, 0, 2, 0, 1); cyc();
        put(1, 0, 0, 2, 0, 0); cyc();

        // R9 / R10: walk every transition of the mode code
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                tag = "R9";
                mode_in = 2'(a);
                put(int'($urandom_range(0, 16383)), 0, 0, 3, 1, 0); cyc();
                tag = "R10";
                mode_in = 2'(b);
                put(int'($urandom_range(0, 16383)), 0, 1, 16000, 0, 0); cyc();
            end
        end

        // R11: outputs held at zero while pipeline runs
        tag = "R11";
        mode_in = 2'b10;
        oe = 1'b0;
        put(1111, 0, 0, 2222, 0, 0); cyc();
        put(3333, 1, 0, 4444, 0, 0); cyc();
        put(5555, 0, 0, 6666, 0, 1); cyc();
        // raise enable between edges: last registered sample must appear
        #1;
        oe = 1'b1;
        #0.5;
        check(int'(i_data) == fmt(5555, 0, 0, 2), "R11", "i_data after oe", int'(i_data), fmt(5555, 0, 0, 2));
        check(int'(q_data) == fmt(6666, 0, 1, 2), "R11", "q_data after oe", int'(q_data), fmt(6666, 0, 1, 2));
        check(ovf == 1'b1, "R11", "ovf after oe", int'(ovf), 1);
        put(0, 0, 0, 0, 0, 0);
        cyc();
        cyc();

        summary();
        $finish;
    end

endmodule